// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Unit

This block sits in a core's memory stage and tracks the single reservation used by load-reserved / store-conditional pairs. A load-reserved passes the memory read data to the destination register and arms a reservation on the cache block that holds its address. A later store-conditional to the same block performs its write and returns 0 only if nothing broke the reservation in between. Otherwise it suppresses the write and returns 1. Atomicity is detected, not enforced. Anything that could let another agent change the block clears the reservation: a trap (interrupt or exception), a context switch, or a coherence invalidate of the block.

All outputs are combinational from the current memory-stage operation and the stored reservation. Only the reservation register, holding a valid bit and a block tag, is clocked. The cache and the decoder are outside this block. The cache supplies the load data and takes the gated write. The coherence fabric supplies invalidates.

Top module: `lrsc_resv_unit`

## Requirements
- R1: After reset no reservation exists, so a store-conditional issued before any load-reserved fails.
- R2: A load-reserved (op_i = 1) with no trap or context switch drives rd_we_o = 1 and rd_data_o = ld_data_i, keeps mem_we_o = 0, and arms the reservation on its block.
- R3: A store-conditional (op_i = 2) that succeeds drives mem_we_o = 1, mem_addr_o = addr_i, mem_wdata_o = st_data_i, rd_we_o = 1 and rd_data_o = 0.
- R4: A store-conditional that fails drives mem_we_o = 0, rd_we_o = 1 and rd_data_o = 1.
- R5: Addresses are compared by block, meaning addr >> BLK_OFS_W with 6 offset bits by default. A store-conditional to another byte of the reserved block succeeds, and one to a different block fails.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails.
- R7: A trap (trap_i = 1) clears the reservation. In the same cycle as a load-reserved or store-conditional it suppresses all register and memory writes, and it does not arm a reservation.
- R8: A context switch (ctx_sw_i = 1) behaves like a trap: the reservation is cleared and the following store-conditional fails.
- R9: An invalidate (inv_valid_i = 1) whose block matches the reservation clears it. An invalidate to another block leaves it intact.
- R10: An invalidate of the reserved block in the same cycle as a store-conditional wins: the store fails. An invalidate of a load-reserved's own block in its cycle leaves no reservation.
- R11: A load-reserved replaces any earlier reservation with its own block.
- R12: op_i values 0 and 3 produce no register or memory write and do not change the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Memory-stage operation present |
| op_i | input | 2 | 0 none, 1 load-reserved, 2 store-conditional, 3 none |
| addr_i | input | ADDR_W | Operation byte address |
| ld_data_i | input | DATA_W | Memory read data for a load-reserved |
| st_data_i | input | DATA_W | Store data for a store-conditional |
| trap_i | input | 1 | Interrupt or exception taken this cycle |
| ctx_sw_i | input | 1 | Context switch this cycle |
| inv_valid_i | input | 1 | Coherence invalidate present |
| inv_addr_i | input | ADDR_W | Invalidated address |
| mem_we_o | output | 1 | Gated memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |
| rd_we_o | output | 1 | Destination register write enable |
| rd_data_o | output | DATA_W | Destination register value |

## Verification
The hardest case to reach from the ports is an invalidate that hits the reserved block in the exact cycle a store-conditional is evaluated. Uniform random addresses almost never produce it, because it needs an armed reservation, a matching store block and a matching invalidate block all at once. The directed phase builds it explicitly, including an invalidate that differs from the reserved address only in its offset bits. The random phase then draws all addresses from a pool of three blocks with random offsets, so same-block collisions among load, store and invalidate happen often.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LR   = 2'd1,
    OP_SC   = 2'd2,
    OP_RSVD = 2'd3
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_blk_cmp.sv
module lrsc_blk_cmp #(
  parameter int ADDR_W    = 32,
  parameter int BLK_OFS_W = 6
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              same_o
);
  generate
    if (BLK_OFS_W == 0) begin : g_word
      assign same_o = (a_i == b_i);
    end else begin : g_blk
      assign same_o = (a_i[ADDR_W-1:BLK_OFS_W] == b_i[ADDR_W-1:BLK_OFS_W]);
    end
  endgenerate
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [TAG_W-1:0] arm_tag_i,
  input  logic             clr_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (arm_i) begin
      valid_o <= 1'b1;
      tag_o   <= arm_tag_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_clear_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !arm_i) |=> !valid_o);
  assert_arm_holds_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (valid_o && tag_o == $past(arm_tag_i)));
  assert_idle_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !clr_i) |=> ($stable(valid_o) && $stable(tag_o)));
endmodule

// File: rtl/lrsc_sc_gate.sv
module lrsc_sc_gate
  import lrsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              op_valid_i,
  input  lrsc_op_e          op_i,
  input  logic              trap_i,
  input  logic              ctx_sw_i,
  input  logic              resv_valid_i,
  input  logic              cur_hit_i,
  input  logic              inv_resv_hit_i,
  input  logic              inv_cur_hit_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              lr_arm_o,
  output logic              resv_clr_o,
  output logic              mem_we_o,
  output logic              rd_we_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic kill, is_lr, is_sc, sc_pass;

  always_comb begin
    kill    = trap_i | ctx_sw_i;
    is_lr   = op_valid_i && (op_i == OP_LR);
    is_sc   = op_valid_i && (op_i == OP_SC);
    // invalidate in the evaluation cycle beats the store
    sc_pass = is_sc && !kill && resv_valid_i && cur_hit_i && !inv_resv_hit_i;

    lr_arm_o   = is_lr && !kill && !inv_cur_hit_i;
    resv_clr_o = kill || is_lr || is_sc || inv_resv_hit_i;

    mem_we_o  = sc_pass;
    rd_we_o   = (is_lr || is_sc) && !kill;
    rd_data_o = '0;
    if (is_lr)                rd_data_o = ld_data_i;
    else if (is_sc && !sc_pass) rd_data_o = DATA_W'(1);
  end

  always_comb begin
    assert_we_only_sc_R3: assert (!mem_we_o || is_sc);
    assert_sc_code_R4: assert (!(is_sc && rd_we_o) || ((rd_data_o == '0) == mem_we_o));
    assert_trap_no_wb_R7: assert (!kill || (!mem_we_o && !rd_we_o));
    assert_inv_wins_R10: assert (!(is_sc && inv_resv_hit_i) || !mem_we_o);
  end
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BLK_OFS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              trap_i,
  input  logic              ctx_sw_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              rd_we_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int TAG_W = ADDR_W - BLK_OFS_W;

  logic              resv_valid;
  logic [TAG_W-1:0]  resv_tag;
  logic [ADDR_W-1:0] resv_addr;
  logic              cur_same, inv_resv_same, inv_cur_same;
  logic              lr_arm, resv_clr;

  generate
    if (BLK_OFS_W == 0) begin : g_nofs
      assign resv_addr = resv_tag;
    end else begin : g_ofs
      assign resv_addr = {resv_tag, {BLK_OFS_W{1'b0}}};
    end
  endgenerate

  lrsc_blk_cmp #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W)) u_cmp_cur (
    .a_i(addr_i), .b_i(resv_addr), .same_o(cur_same));
  lrsc_blk_cmp #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W)) u_cmp_inv_resv (
    .a_i(inv_addr_i), .b_i(resv_addr), .same_o(inv_resv_same));
  lrsc_blk_cmp #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W)) u_cmp_inv_cur (
    .a_i(inv_addr_i), .b_i(addr_i), .same_o(inv_cur_same));

  lrsc_sc_gate #(.DATA_W(DATA_W)) u_gate (
    .op_valid_i     (op_valid_i),
    .op_i           (lrsc_op_e'(op_i)),
    .trap_i         (trap_i),
    .ctx_sw_i       (ctx_sw_i),
    .resv_valid_i   (resv_valid),
    .cur_hit_i      (cur_same),
    .inv_resv_hit_i (inv_valid_i && resv_valid && inv_resv_same),
    .inv_cur_hit_i  (inv_valid_i && inv_cur_same),
    .ld_data_i      (ld_data_i),
    .lr_arm_o       (lr_arm),
    .resv_clr_o     (resv_clr),
    .mem_we_o       (mem_we_o),
    .rd_we_o        (rd_we_o),
    .rd_data_o      (rd_data_o)
  );

  lrsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (lr_arm),
    .arm_tag_i (addr_i[ADDR_W-1:BLK_OFS_W]),
    .clr_i     (resv_clr),
    .valid_o   (resv_valid),
    .tag_o     (resv_tag)
  );

  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = st_data_i;

  assert_ctx_fails_sc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_sw_i && !(op_valid_i && op_i == 2'd1)) |=> !(op_valid_i && op_i == 2'd2 && mem_we_o));
  assert_sc_then_no_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'd2) |=> !(op_valid_i && op_i == 2'd2 && mem_we_o));
  assert_inv_hit_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && resv_valid && inv_resv_same && !lr_arm) |=> !resv_valid);
endmodule

// File: tb/lrsc_resv_unit_tb_top.sv
module lrsc_resv_unit_tb_top;
  localparam int AW = 32, DW = 32, OFS = 6;

  logic clk = 0, rst_n = 0;
  logic op_valid; logic [1:0] op;
  logic [AW-1:0] addr, inv_addr;
  logic [DW-1:0] ld_data, st_data;
  logic trap, ctx, inv_v;
  logic mem_we, rd_we; logic [AW-1:0] mem_addr; logic [DW-1:0] mem_wdata, rd_data;

  always #2 clk = ~clk;

  lrsc_resv_unit #(.ADDR_W(AW), .DATA_W(DW), .BLK_OFS_W(OFS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .addr_i(addr),
    .ld_data_i(ld_data), .st_data_i(st_data), .trap_i(trap), .ctx_sw_i(ctx),
    .inv_valid_i(inv_v), .inv_addr_i(inv_addr), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .rd_we_o(rd_we), .rd_data_o(rd_data));

  int errs = 0, checks = 0;
  bit m_v = 0; logic [AW-OFS-1:0] m_tag = '0;

  function automatic logic [AW-OFS-1:0] blk(input logic [AW-1:0] a);
    return a[AW-1:OFS];
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle, check against model, advance model
  task automatic step(input string req, input logic v, input logic [1:0] o, input logic [AW-1:0] a,
                      input logic tr, input logic cs, input logic iv, input logic [AW-1:0] ia);
    bit kill, is_lr, is_sc, pass, inv_res, inv_cur, e_rwe;
    logic [DW-1:0] e_rd;
    @(negedge clk);
    op_valid = v; op = o; addr = a; trap = tr; ctx = cs; inv_v = iv; inv_addr = ia;
    ld_data = $urandom; st_data = $urandom;
    #1;
    kill = tr | cs; is_lr = v && o == 2'd1; is_sc = v && o == 2'd2;
    inv_res = iv && m_v && blk(ia) == m_tag;
    inv_cur = iv && blk(ia) == blk(a);
    pass = is_sc && !kill && m_v && blk(a) == m_tag && !inv_res;
    e_rwe = (is_lr || is_sc) && !kill;
    e_rd = is_lr ? ld_data : (pass ? '0 : DW'(1));
    chk(req, "mem_we", DW'(mem_we), DW'(pass));
    chk(req, "rd_we", DW'(rd_we), DW'(e_rwe));
    if (e_rwe) chk(req, "rd_data", rd_data, e_rd);
    if (pass) begin
      chk(req, "mem_addr", mem_addr, a);
      chk(req, "mem_wdata", mem_wdata, st_data);
    end
    if (is_lr && !kill && !inv_cur) begin m_v = 1; m_tag = blk(a); end
    else if (kill || is_lr || is_sc || inv_res) m_v = 0;
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1000, B = 32'h0000_2040, C = 32'h0000_3080;

  initial begin
    op_valid = 0; op = 0; addr = 0; inv_addr = 0; ld_data = 0; st_data = 0;
    trap = 0; ctx = 0; inv_v = 0;
    void'($urandom(1234));
    #1;
    chk("R1", "reset mem_we", DW'(mem_we), 0);
    chk("R1", "reset rd_we", DW'(rd_we), 0);
    repeat (2) @(posedge clk);
    rst_n = 1;
    step("R1", 1, 2, A, 0, 0, 0, 0);                 // SC with no reservation
    step("R2", 1, 1, A, 0, 0, 0, 0);                 // LR
    step("R3", 1, 2, A + 4, 0, 0, 0, 0);             // R5 same block, other byte
    step("R6", 1, 2, A, 0, 0, 0, 0);                 // second SC fails
    step("R2", 1, 1, A, 0, 0, 0, 0);
    step("R5", 1, 2, B, 0, 0, 0, 0);                 // other block fails
    step("R6", 1, 2, A, 0, 0, 0, 0);                 // failed SC also cleared
    step("R7", 1, 1, A, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 0, 0);                 // trap between
    step("R7", 1, 2, A, 0, 0, 0, 0);
    step("R7", 1, 1, A, 1, 0, 0, 0);                 // LR with trap: no arm, no wb
    step("R7", 1, 2, A, 0, 0, 0, 0);
    step("R8", 1, 1, B, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0);
    step("R8", 1, 2, B, 0, 0, 0, 0);
    step("R9", 1, 1, B, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, C);                 // unrelated invalidate
    step("R9", 1, 2, B, 0, 0, 0, 0);                 // still passes
    step("R9", 1, 1, B, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, B + 8);             // same block invalidate
    step("R9", 1, 2, B, 0, 0, 0, 0);
    step("R10", 1, 1, C, 0, 0, 0, 0);
    step("R10", 1, 2, C, 0, 0, 1, C + 12);           // invalidate wins
    step("R10", 1, 1, A, 0, 0, 1, A + 3);            // LR own-block invalidate
    step("R10", 1, 2, A, 0, 0, 0, 0);
    step("R11", 1, 1, A, 0, 0, 0, 0);
    step("R11", 1, 1, C, 0, 0, 0, 0);                // replaces
    step("R11", 1, 2, A, 0, 0, 0, 0);
    step("R12", 1, 1, B, 0, 0, 0, 0);
    step("R12", 1, 3, B, 0, 0, 0, 0);
    step("R12", 1, 0, A, 0, 0, 0, 0);
    step("R12", 0, 2, A, 0, 0, 0, 0);
    step("R12", 1, 2, B, 0, 0, 0, 0);                // survived
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pool [3];
      logic [AW-1:0] ra, ia;
      pool[0] = A; pool[1] = B; pool[2] = C;
      ra = pool[$urandom_range(2)] | AW'($urandom_range(63));
      ia = pool[$urandom_range(2)] | AW'($urandom_range(63));
      step("R3", $urandom_range(7) != 0, 2'($urandom_range(3)), ra,
           $urandom_range(15) == 0, $urandom_range(19) == 0, $urandom_range(3) == 0, ia);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule